// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller on a simple 32-bit register bus. Each cycle the bus presents an address, write data and a write strobe. Read data is decoded combinationally from the address.

The main bank has up to 32 pins. Each pin has a direction bit, an output value, a synchronized input readback and its own interrupt detector. A detector can be set for a rising or falling edge, for both edges, or for an active-high or active-low level. Edge events are latched until software clears them. Level events follow the pin and are silenced with a mask bit. Each pin drives its own interrupt line, and one combined line ORs all of them.

A parameter adds a narrow second bank inside the same register window. It has direction, output and input readback, and no interrupt logic. Two further registers are plain storage: a data-source word and a debounce word. The version word returns a constant set by a parameter.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register reads 0, `pa_out`, `pa_oe`, `pb_out`, `pb_oe`, `pa_irq` and `irq_any` are 0, and offset 0x64 reads the `VERSION` parameter.
- R2: A word written to offset 0x00 (output), 0x04 (direction), 0x08 (data source) or 0x48 (debounce) reads back unchanged. `pa_out` equals the output word. `pa_oe` equals the direction word, where 1 drives the pin and 0 makes it an input.
- R3: Offset 0x50 returns `pa_in` through a two-flop synchronizer: a change is not visible after one clock edge and is visible after the second.
- R4: With type bit = 1 (edge) and both-edge bit = 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge. The opposite edge does nothing. The latched bit stays set after the pin returns, and `pa_irq` rises on the third clock edge after the pin changes.
- R5: A both-edge bit of 1 (offset 0x68) latches every rising and every falling edge, whatever the type (0x38) and polarity (0x3C) bits hold. It never acts as a level detector.
- R6: Writing 1 to a pin's bit at offset 0x4C clears that pin's latched edge status (raw status at offset 0x44). Writing 0 leaves it unchanged.
- R7: With type = 0 and both-edge = 0, raw status follows the pin's active level (polarity 1 = high, 0 = low) and is not latched. Writing to the clear register does not remove it.
- R8: A mask bit of 1 (offset 0x34) forces that pin's `pa_irq` bit and its masked status bit (offset 0x40) to 0, while raw status still records the event.
- R9: Raw status is captured only while the pin's enable bit (offset 0x30) is 1. Writing the enable bit to 0 clears any latched status for that pin.
- R10: `irq_any` is 1 exactly when any masked status bit is 1. Offset 0x40 equals raw AND enable AND NOT mask.
- R11: Port B uses output offset 0x0C, direction offset 0x10 and synchronized input offset 0x54, and is `NB` bits wide. Its pins never change any interrupt output or raw status.
- R12: The clear register reads as 0. Unmapped offsets read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pa_in | input | NA | Port A pin inputs |
| pa_out | output | NA | Port A output values |
| pa_oe | output | NA | Port A output enables |
| pa_irq | output | NA | Per-pin interrupt lines |
| irq_any | output | 1 | OR of all pin interrupts |
| pb_in | input | NB | Port B pin inputs |
| pb_out | output | NB | Port B output values |
| pb_oe | output | NB | Port B output enables |

## Verification
The bench builds the controller with its defaults: a full 32-pin Port A, an 8-pin Port B present, and version 0x01020304. This reaches full-width readback of every storage word and places Port B's three registers at their offsets inside the shared window. It also shows that the upper bits of a write to the narrow port are dropped. Because the interrupt settings are independent per pin, the bench can put different pins in rising, falling, both-edge, active-high and active-low modes at the same time. It then checks that these modes do not disturb one another and that `irq_any` combines them.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int REG_W = 32;

    // register offsets within the window
    localparam logic [7:0] OFS_OUT   = 8'h00;
    localparam logic [7:0] OFS_DIR   = 8'h04;
    localparam logic [7:0] OFS_SRC   = 8'h08;
    localparam logic [7:0] OFS_B_OUT = 8'h0C;
    localparam logic [7:0] OFS_B_DIR = 8'h10;
    localparam logic [7:0] OFS_IEN   = 8'h30;
    localparam logic [7:0] OFS_MASK  = 8'h34;
    localparam logic [7:0] OFS_TYPE  = 8'h38;
    localparam logic [7:0] OFS_POL   = 8'h3C;
    localparam logic [7:0] OFS_STAT  = 8'h40;
    localparam logic [7:0] OFS_RAW   = 8'h44;
    localparam logic [7:0] OFS_DBNC  = 8'h48;
    localparam logic [7:0] OFS_CLR   = 8'h4C;
    localparam logic [7:0] OFS_IN    = 8'h50;
    localparam logic [7:0] OFS_B_IN  = 8'h54;
    localparam logic [7:0] OFS_VER   = 8'h64;
    localparam logic [7:0] OFS_BOTH  = 8'h68;

    typedef struct packed {
        logic [REG_W-1:0] outv;
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] ien;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] ltype;
        logic [REG_W-1:0] pol;
        logic [REG_W-1:0] dbnc;
        logic [REG_W-1:0] both;
        logic [REG_W-1:0] b_out;
        logic [REG_W-1:0] b_dir;
    } cfg_t;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta  = pin_i;
        s_d.stage = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stage;
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] ien_nx_i,
    input  logic [W-1:0] ien_i,
    input  logic [W-1:0] type_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] irq_o
);
    typedef struct packed {
        logic [W-1:0] raw;
        logic [W-1:0] prev;
    } det_t;

    det_t d_d, d_q;
    logic [W-1:0] rise, fall, edge_hit, edge_mode, lvl_hit;

    always_comb begin
        rise      = sync_i & ~d_q.prev;
        fall      = ~sync_i & d_q.prev;
        edge_mode = type_i | both_i;
        edge_hit  = (both_i & (rise | fall))
                  | (~both_i & pol_i & rise)
                  | (~both_i & ~pol_i & fall);
        lvl_hit   = ~(sync_i ^ pol_i);
        d_d.prev  = sync_i;
        d_d.raw   = ien_nx_i & ((edge_mode & ((d_q.raw & ~clr_i) | edge_hit))
                              | (~edge_mode & lvl_hit));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign raw_o = d_q.raw;
    assign irq_o = d_q.raw & ien_i & ~mask_i;

    for (genvar i = 0; i < W; i++) begin : g_pin_chk
        // R6
        clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode[i] && clr_i[i] && !edge_hit[i]) |=> !d_q.raw[i]);
        // R4
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode[i] && d_q.raw[i] && !clr_i[i] && ien_nx_i[i]) |=> d_q.raw[i]);
        // R9
        en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ien_nx_i[i] |=> !d_q.raw[i]);
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int          NA      = 32,
    parameter int          NB      = 8,
    parameter int          HAS_B   = 1,
    parameter logic [31:0] VERSION = 32'h0102_0304
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic          bus_we,
    output logic [31:0]   bus_rdata,
    input  logic [NA-1:0] pa_in,
    output logic [NA-1:0] pa_out,
    output logic [NA-1:0] pa_oe,
    output logic [NA-1:0] pa_irq,
    output logic          irq_any,
    input  logic [NB-1:0] pb_in,
    output logic [NB-1:0] pb_out,
    output logic [NB-1:0] pb_oe
);
    localparam logic [31:0] A_MASK = (NA >= 32) ? '1 : ((32'd1 << NA) - 32'd1);
    localparam logic [31:0] B_MASK = (NB >= 32) ? '1 : ((32'd1 << NB) - 32'd1);

    cfg_t          c_d, c_q;
    logic [NA-1:0] clr_pulse, a_sync, a_raw;
    logic [NB-1:0] b_sync;

    always_comb begin
        c_d       = c_q;
        clr_pulse = '0;
        if (bus_we) begin
            case (bus_addr)
                OFS_OUT:   c_d.outv  = bus_wdata & A_MASK;
                OFS_DIR:   c_d.dir   = bus_wdata & A_MASK;
                OFS_SRC:   c_d.src   = bus_wdata & A_MASK;
                OFS_IEN:   c_d.ien   = bus_wdata & A_MASK;
                OFS_MASK:  c_d.mask  = bus_wdata & A_MASK;
                OFS_TYPE:  c_d.ltype = bus_wdata & A_MASK;
                OFS_POL:   c_d.pol   = bus_wdata & A_MASK;
                OFS_DBNC:  c_d.dbnc  = bus_wdata & A_MASK;
                OFS_BOTH:  c_d.both  = bus_wdata & A_MASK;
                OFS_CLR:   clr_pulse = bus_wdata[NA-1:0];
                OFS_B_OUT: if (HAS_B != 0) c_d.b_out = bus_wdata & B_MASK;
                OFS_B_DIR: if (HAS_B != 0) c_d.b_dir = bus_wdata & B_MASK;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    pinbank_sync #(.W(NA)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .pin_i(pa_in), .sync_o(a_sync)
    );

    pinbank_irq #(.W(NA)) u_irq_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (a_sync),
        .ien_nx_i (c_d.ien[NA-1:0]),
        .ien_i    (c_q.ien[NA-1:0]),
        .type_i   (c_q.ltype[NA-1:0]),
        .pol_i    (c_q.pol[NA-1:0]),
        .both_i   (c_q.both[NA-1:0]),
        .mask_i   (c_q.mask[NA-1:0]),
        .clr_i    (clr_pulse),
        .raw_o    (a_raw),
        .irq_o    (pa_irq)
    );

    generate
        if (HAS_B != 0) begin : g_port_b
            pinbank_sync #(.W(NB)) u_sync_b (
                .clk(clk), .rst_n(rst_n), .pin_i(pb_in), .sync_o(b_sync)
            );
        end else begin : g_no_port_b
            assign b_sync = '0;
        end
    endgenerate

    assign pa_out  = c_q.outv[NA-1:0];
    assign pa_oe   = c_q.dir[NA-1:0];
    assign pb_out  = c_q.b_out[NB-1:0];
    assign pb_oe   = c_q.b_dir[NB-1:0];
    assign irq_any = |pa_irq;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_OUT:   bus_rdata = c_q.outv;
            OFS_DIR:   bus_rdata = c_q.dir;
            OFS_SRC:   bus_rdata = c_q.src;
            OFS_IEN:   bus_rdata = c_q.ien;
            OFS_MASK:  bus_rdata = c_q.mask;
            OFS_TYPE:  bus_rdata = c_q.ltype;
            OFS_POL:   bus_rdata = c_q.pol;
            OFS_DBNC:  bus_rdata = c_q.dbnc;
            OFS_BOTH:  bus_rdata = c_q.both;
            OFS_STAT:  bus_rdata[NA-1:0] = pa_irq;
            OFS_RAW:   bus_rdata[NA-1:0] = a_raw;
            OFS_IN:    bus_rdata[NA-1:0] = a_sync;
            OFS_B_OUT: bus_rdata = c_q.b_out;
            OFS_B_DIR: bus_rdata = c_q.b_dir;
            OFS_B_IN:  bus_rdata[NB-1:0] = b_sync;
            OFS_VER:   bus_rdata = VERSION;
            default:   bus_rdata = '0;
        endcase
    end

    // R8
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_MASK && bus_wdata == A_MASK) |=> !irq_any);
    // R12
    clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CLR) |-> (bus_rdata == 32'd0));
endmodule

// File: tb/pinbank_ctrl_tb_top.sv
module pinbank_ctrl_tb_top;
    localparam logic [31:0] VER = 32'h0102_0304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [31:0] pa_in = '0;
    logic [31:0] pa_out, pa_oe, pa_irq;
    logic        irq_any;
    logic [7:0]  pb_in = '0;
    logic [7:0]  pb_out, pb_oe;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pinbank_ctrl #(.NA(32), .NB(8), .HAS_B(1), .VERSION(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
        .bus_rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pa_irq(pa_irq), .irq_any(irq_any), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
    );

    always #10 clk = ~clk;

    // {offset, write data, expected readback}
    localparam logic [71:0] VEC [8] = '{
        {8'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h04, 32'h0F0F_00FF, 32'h0F0F_00FF},
        {8'h08, 32'h1234_5678, 32'h1234_5678},
        {8'h48, 32'hCAFE_0001, 32'hCAFE_0001},
        {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h4C, 32'h0000_0000, 32'h0000_0000},
        {8'h64, 32'hFFFF_FFFF, VER},
        {8'h0C, 32'hFFFF_FF5A, 32'h0000_005A}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(8'h00, v); chk("R1 out", v, 0);
        rd(8'h04, v); chk("R1 dir", v, 0);
        rd(8'h30, v); chk("R1 ien", v, 0);
        rd(8'h44, v); chk("R1 raw", v, 0);
        rd(8'h64, v); chk("R1 version", v, VER);
        chk("R1 pa_oe", pa_oe, 0);
        chk("R1 irq", {31'd0, irq_any}, 0);

        // R2 R12 R11 vector walk
        for (int k = 0; k < 8; k++) begin
            wr(VEC[k][71:64], VEC[k][63:32]);
            rd(VEC[k][71:64], v);
            chk("R2/R11/R12 readback", v, VEC[k][31:0]);
        end
        chk("R2 pa_out", pa_out, 32'hDEAD_BEEF);
        chk("R2 pa_oe", pa_oe, 32'h0F0F_00FF);
        chk("R11 pb_out wide write", {24'd0, pb_out}, 32'h5A);

        // R3 synchronizer latency
        pa_in = 32'h8000_0100;
        tick(1); rd(8'h50, v); chk("R3 one edge", v, 0);
        tick(1); rd(8'h50, v); chk("R3 two edges", v, 32'h8000_0100);

        // configure: bit0 rise, bit1 fall, bit2 both, bit3 high level
        wr(8'h38, 32'h0000_0023);
        wr(8'h3C, 32'h0000_0029);
        wr(8'h68, 32'h0000_0004);
        wr(8'h30, 32'h0000_000F);
        tick(1);
        chk("R5 both overrides level-low", {31'd0, irq_any}, 0);

        // R4 rising
        pa_in[0] = 1'b1;
        tick(2); chk("R4 not yet", pa_irq, 0);
        tick(1); chk("R4 rise latched", pa_irq, 32'h1);
        chk("R10 any", {31'd0, irq_any}, 1);
        pa_in[0] = 1'b0;
        tick(3); chk("R4 held after return", pa_irq, 32'h1);
        wr(8'h4C, 32'h0); rd(8'h44, v); chk("R6 write 0 no effect", v, 32'h1);
        wr(8'h4C, 32'h1); rd(8'h44, v); chk("R6 write 1 clears", v, 0);

        // R4 falling
        pa_in[1] = 1'b1;
        tick(3); chk("R4 rise ignored on falling pin", pa_irq, 0);
        pa_in[1] = 1'b0;
        tick(3); chk("R4 fall latched", pa_irq, 32'h2);
        wr(8'h4C, 32'h2);

        // R5 both edges
        pa_in[2] = 1'b1;
        tick(3); chk("R5 rise", pa_irq, 32'h4);
        wr(8'h4C, 32'h4); chk("R5 cleared", pa_irq, 0);
        pa_in[2] = 1'b0;
        tick(3); chk("R5 fall", pa_irq, 32'h4);
        wr(8'h4C, 32'h4);

        // R7 level high
        pa_in[3] = 1'b1;
        tick(3); chk("R7 level active", pa_irq, 32'h8);
        wr(8'h4C, 32'h8); chk("R7 clear no effect", pa_irq, 32'h8);
        pa_in[3] = 1'b0;
        tick(3); chk("R7 follows pin", pa_irq, 0);

        // R8 mask
        pa_in[3] = 1'b1;
        tick(3);
        wr(8'h34, 32'h8);
        chk("R8 irq masked", pa_irq, 0);
        rd(8'h40, v); chk("R8 status masked", v, 0);
        rd(8'h44, v); chk("R8 raw kept", v, 32'h8);
        wr(8'h34, 32'h0); chk("R8 unmask", pa_irq, 32'h8);

        // R10 two sources
        pa_in[0] = 1'b1;
        tick(3); chk("R10 two pins", pa_irq, 32'h9);
        rd(8'h40, v); chk("R10 status", v, 32'h9);
        wr(8'h34, 32'hFFFF_FFFF); chk("R10 all masked", {31'd0, irq_any}, 0);
        wr(8'h34, 32'h0);
        wr(8'h4C, 32'h1);
        pa_in[3] = 1'b0;
        tick(3); chk("R10 none", {31'd0, irq_any}, 0);

        // R9 enable gating
        pa_in[5] = 1'b1;
        tick(3); rd(8'h44, v); chk("R9 disabled pin not captured", v & 32'h20, 0);
        pa_in[0] = 1'b0; tick(3);
        pa_in[0] = 1'b1; tick(3);
        rd(8'h44, v); chk("R9 latched before disable", v, 32'h1);
        wr(8'h30, 32'h0000_000E);
        rd(8'h44, v); chk("R9 disable clears", v, 0);

        // R7 active-low level on bit4
        wr(8'h30, 32'h0000_0010);
        tick(1); chk("R7 low level active", pa_irq, 32'h10);
        pa_in[4] = 1'b1;
        tick(3); chk("R7 low level released", pa_irq, 0);

        // R11 port B
        wr(8'h0C, 32'h0000_00A5);
        wr(8'h10, 32'h0000_003C);
        chk("R11 pb_out", {24'd0, pb_out}, 32'hA5);
        chk("R11 pb_oe", {24'd0, pb_oe}, 32'h3C);
        pb_in = 8'h5A;
        tick(2); rd(8'h54, v); chk("R11 pb input", v, 32'h5A);
        pb_in = 8'hFF;
        tick(3);
        chk("R11 no irq from port B", {31'd0, irq_any}, 0);
        rd(8'h44, v); chk("R11 raw untouched", v, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule